// File: doc/BRIEF.md
# SPI Chip-Select Sequencer with Setup and Hold Delays

This block sits between a register bank and an SPI shift engine and owns the chip-select pins. When a word is offered, it pulls the chosen active-low select lines down. It then waits a programmable lead time before it strobes the shift engine to begin. When the shift engine reports the word finished, the block keeps the select asserted for a programmable trail time and then returns every line to its idle level. The idle level of each line comes from a small idle-level register.

A per-word hold flag keeps the select asserted between words. A following word then goes straight to the shift engine with no lead time and no release. A timer-bypass bit removes both the lead and the trail waits. The select field, the hold flag, the delays and the bypass bit are copied when a word is accepted. A write that lands while a word is in flight therefore only affects the next word. Writing the select field and hold flag alone never starts a word; a word starts only when `word_valid` is raised, which stands for a write to the low data half.

All delays are counted in module clock cycles. The reset sets no added wait.

Top module: `spi_csel_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, every `cs_n` line is high and `start` is low. Reset sets the idle-level register to all ones, the select field to all ones, and the hold flag, both delays and the bypass bit to zero.
- R2: Outside a word, `cs_n` equals the idle-level register. A write through `idle_wr` shows on the pins in the cycle after it is sampled.
- R3: During a word (lead, transfer and trail phases), line i is driven low when bit i of the word's select field `sel_n` is 0. When that bit is 1, line i stays at its idle level.
- R4: With lead count L, the lines are asserted for exactly L cycles before the cycle in which `start` is high. With L = 0, `start` is high in the first asserted cycle, one cycle after acceptance.
- R5: With trail count T, the select stays asserted for exactly T cycles after the cycle in which `word_done` is sampled, and is then released. With T = 0 it is released in the cycle right after `word_done`.
- R6: When the bypass bit `tmr_off` is set for a word, both waits are zero whatever the delay counts hold.
- R7: With the hold flag set for a word, the select stays asserted after the word. A word offered during the trail wait, or after it has elapsed, gets `start` in the next cycle with no lead wait and no release in between.
- R8: While the select is being held after a hold word, a field write that clears the hold flag releases the lines. They return to idle in the second cycle after the write is sampled.
- R9: A field write through `sel_wr` with `word_valid` low never raises `start` and leaves `cs_n` unchanged.
- R10: Field, delay and bypass values are captured when a word is accepted. Writes made during the word, or in the acceptance cycle itself, change neither its select lines nor its timing, and apply to the next word.
- R11: A release lasts one cycle and is followed by an idle cycle in which a waiting word is accepted. Between two non-hold words the lines therefore rest at idle level for exactly two cycles when the lead is zero.
- R12: `start` is a single-cycle pulse, exactly one per accepted word. It is only raised after a cycle in which `word_valid` was high, and the source holds `word_valid` until it sees `start`.
- R13: A word offered while a non-hold word is still in its trail wait is not accepted until the release and the following idle cycle have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all delays count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the select field and hold flag |
| sel_n | input | NUM_CS | Select field, bit i low selects line i |
| sel_hold | input | 1 | Hold flag: keep the select asserted between words |
| dly_wr | input | 1 | Write strobe for the delay counts |
| dly_lead | input | DLY_W | Cycles from select assertion to start |
| dly_trail | input | DLY_W | Cycles from word end to select release |
| tmr_wr | input | 1 | Write strobe for the bypass bit |
| tmr_off | input | 1 | Bypass both delays when set |
| idle_wr | input | 1 | Write strobe for the idle-level register |
| idle_lvl | input | NUM_CS | Idle level of each select line |
| word_valid | input | 1 | A word is offered; held until start |
| word_done | input | 1 | Shift engine finished the current word |
| start | output | 1 | One-cycle strobe that lets the shift engine begin |
| cs_n | output | NUM_CS | Active-low chip-select pins |

## Verification
The bench runs the lead and trail counts at zero, at small values and under bypass. A design that is off by one in either counter shifts `start` or the release by a cycle, and the cycle-by-cycle reference flags that at once.

It offers a word in the middle of a held trail wait and another in the middle of a non-hold trail wait. A design that confused the two would either release the select between held words or accept a word before the release.

It rewrites the select field during a word and clears the hold flag while the select is parked. Design that read live fields instead of the captured ones would move the select mid-word. A design that ignored the hold flag would never release.

// File: rtl/spi_csel_pkg.sv
// Shared types for the chip-select sequencer.
// Assumes nothing beyond a single clock domain.
package spi_csel_pkg;

    // Phases of one word as seen on the chip-select pins.
    typedef enum logic [2:0] {
        CSQ_IDLE    = 3'd0,
        CSQ_LEAD    = 3'd1,
        CSQ_XFER    = 3'd2,
        CSQ_TRAIL   = 3'd3,
        CSQ_RELEASE = 3'd4
    } csq_state_e;

endpackage

// File: rtl/csel_cfg_regs.sv
// Configuration storage for the sequencer: the pending select field and
// hold flag, the lead and trail delay counts, the timer bypass bit and the
// idle level of every select line. Each group has its own write strobe.
// Assumes the strobes are single-cycle and synchronous to clk.
module csel_cfg_regs #(
    parameter int NUM_CS = 2,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [NUM_CS-1:0] sel_n,
    input  logic              sel_hold,
    input  logic              dly_wr,
    input  logic [DLY_W-1:0]  dly_lead,
    input  logic [DLY_W-1:0]  dly_trail,
    input  logic              tmr_wr,
    input  logic              tmr_off,
    input  logic              idle_wr,
    input  logic [NUM_CS-1:0] idle_lvl,
    output logic [NUM_CS-1:0] sel_q,
    output logic              hold_q,
    output logic [DLY_W-1:0]  lead_q,
    output logic [DLY_W-1:0]  trail_q,
    output logic              tmr_q,
    output logic [NUM_CS-1:0] idle_q
);

    // Select field and hold flag, written together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '1;
            hold_q <= 1'b0;
        end else if (sel_wr) begin
            sel_q  <= sel_n;
            hold_q <= sel_hold;
        end
    end

    // Lead and trail delay counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q  <= '0;
            trail_q <= '0;
        end else if (dly_wr) begin
            lead_q  <= dly_lead;
            trail_q <= dly_trail;
        end
    end

    // Timer bypass bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmr_q <= 1'b0;
        else if (tmr_wr) tmr_q <= tmr_off;
    end

    // Idle level of each select line.
    always_ff @(posedge clk) begin
        if (!rst_n)       idle_q <= '1;
        else if (idle_wr) idle_q <= idle_lvl;
    end

endmodule

// File: rtl/csel_seq_fsm.sv
// Word sequencer: accepts a word, captures its configuration, times the
// lead wait, strobes the shift engine, times the trail wait and releases
// (or parks, when the hold flag was set). Delays are counted in clk cycles.
// Assumes word_valid is held by its source until start is seen, and that
// word_done is a single-cycle pulse from the shift engine.
module csel_seq_fsm
    import spi_csel_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              word_done,
    input  logic [NUM_CS-1:0] sel_q,
    input  logic              hold_q,
    input  logic [DLY_W-1:0]  lead_q,
    input  logic [DLY_W-1:0]  trail_q,
    input  logic              tmr_q,
    output csq_state_e        st_o,
    output logic [NUM_CS-1:0] act_sel,
    output logic              cs_active,
    output logic              start
);

    localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;

    csq_state_e        st, st_nx;
    logic [DLY_W-1:0]  cnt, cnt_nx;
    logic              start_nx;
    logic              act_hold;
    logic              act_byp;
    logic [DLY_W-1:0]  act_trail;
    logic              accept;
    logic              lead_none;
    logic [DLY_W-1:0]  trail_eff;

    // A word is taken from idle, or during a held trail/park phase.
    assign accept    = word_valid &&
                       ((st == CSQ_IDLE) || ((st == CSQ_TRAIL) && act_hold));
    assign lead_none = tmr_q || (lead_q == CNT_ZERO);
    assign trail_eff = act_byp ? CNT_ZERO : act_trail;

    // Next-state and counter logic for one word's phases.
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        start_nx = 1'b0;
        unique case (st)
            CSQ_IDLE: begin
                if (word_valid) begin
                    if (lead_none) begin
                        st_nx    = CSQ_XFER;
                        start_nx = 1'b1;
                    end else begin
                        st_nx  = CSQ_LEAD;
                        cnt_nx = lead_q;
                    end
                end
            end
            CSQ_LEAD: begin
                if (cnt == CNT_ONE) begin
                    st_nx    = CSQ_XFER;
                    start_nx = 1'b1;
                end else begin
                    cnt_nx = cnt - CNT_ONE;
                end
            end
            CSQ_XFER: begin
                if (word_done) begin
                    if (trail_eff == CNT_ZERO) begin
                        st_nx  = act_hold ? CSQ_TRAIL : CSQ_RELEASE;
                        cnt_nx = CNT_ZERO;
                    end else begin
                        st_nx  = CSQ_TRAIL;
                        cnt_nx = trail_eff;
                    end
                end
            end
            CSQ_TRAIL: begin
                if (act_hold && word_valid) begin
                    st_nx    = CSQ_XFER;
                    start_nx = 1'b1;
                end else if (cnt > CNT_ONE) begin
                    cnt_nx = cnt - CNT_ONE;
                end else if (!act_hold) begin
                    st_nx = CSQ_RELEASE;
                end else begin
                    cnt_nx = CNT_ZERO;
                    if (!hold_q) st_nx = CSQ_RELEASE;
                end
            end
            CSQ_RELEASE: st_nx = CSQ_IDLE;
            default:     st_nx = CSQ_IDLE;
        endcase
    end

    // State, counter and start strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CSQ_IDLE;
            cnt   <= CNT_ZERO;
            start <= 1'b0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            start <= start_nx;
        end
    end

    // Capture the word's configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel   <= '1;
            act_hold  <= 1'b0;
            act_byp   <= 1'b0;
            act_trail <= CNT_ZERO;
        end else if (accept) begin
            act_sel   <= sel_q;
            act_hold  <= hold_q;
            act_byp   <= tmr_q;
            act_trail <= trail_q;
        end
    end

    assign st_o      = st;
    assign cs_active = (st == CSQ_LEAD) || (st == CSQ_XFER) || (st == CSQ_TRAIL);

endmodule

// File: rtl/csel_pin_drv.sv
// Pin driver: each select line shows its idle level, except during a word
// when a line whose captured field bit is 0 is pulled low.
// Assumes cs_active is a registered phase indication from the sequencer.
module csel_pin_drv #(
    parameter int NUM_CS = 2
) (
    input  logic              cs_active,
    input  logic [NUM_CS-1:0] act_sel,
    input  logic [NUM_CS-1:0] idle_q,
    output logic [NUM_CS-1:0] cs_n
);

    // One driver per select line.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = (cs_active && !act_sel[i]) ? 1'b0 : idle_q[i];
    end

endmodule

// File: rtl/spi_csel_seq.sv
// Top of the chip-select sequencer: configuration registers, word
// sequencer and per-line pin drivers. Assumes one clock domain and a
// shift engine that answers each start with exactly one word_done.
module spi_csel_seq
    import spi_csel_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [NUM_CS-1:0] sel_n,
    input  logic              sel_hold,
    input  logic              dly_wr,
    input  logic [DLY_W-1:0]  dly_lead,
    input  logic [DLY_W-1:0]  dly_trail,
    input  logic              tmr_wr,
    input  logic              tmr_off,
    input  logic              idle_wr,
    input  logic [NUM_CS-1:0] idle_lvl,
    input  logic              word_valid,
    input  logic              word_done,
    output logic              start,
    output logic [NUM_CS-1:0] cs_n
);

    logic [NUM_CS-1:0] sel_q;
    logic              hold_q;
    logic [DLY_W-1:0]  lead_q;
    logic [DLY_W-1:0]  trail_q;
    logic              tmr_q;
    logic [NUM_CS-1:0] idle_q;
    csq_state_e        st_q;
    logic [NUM_CS-1:0] act_sel;
    logic              cs_active;

    csel_cfg_regs #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_n(sel_n), .sel_hold(sel_hold),
        .dly_wr(dly_wr), .dly_lead(dly_lead), .dly_trail(dly_trail),
        .tmr_wr(tmr_wr), .tmr_off(tmr_off),
        .idle_wr(idle_wr), .idle_lvl(idle_lvl),
        .sel_q(sel_q), .hold_q(hold_q), .lead_q(lead_q),
        .trail_q(trail_q), .tmr_q(tmr_q), .idle_q(idle_q)
    );

    csel_seq_fsm #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_done(word_done),
        .sel_q(sel_q), .hold_q(hold_q), .lead_q(lead_q),
        .trail_q(trail_q), .tmr_q(tmr_q),
        .st_o(st_q), .act_sel(act_sel), .cs_active(cs_active),
        .start(start)
    );

    csel_pin_drv #(.NUM_CS(NUM_CS)) u_pins (
        .cs_active(cs_active), .act_sel(act_sel), .idle_q(idle_q),
        .cs_n(cs_n)
    );

endmodule

// File: rtl/spi_csel_seq_chk.sv
// Property checker for the chip-select sequencer, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module spi_csel_seq_chk
    import spi_csel_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DLY_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic              idle_wr,
    input logic              start,
    input logic [NUM_CS-1:0] cs_n,
    input csq_state_e        st,
    input logic [NUM_CS-1:0] idle_q,
    input logic              tmr_q,
    input logic [DLY_W-1:0]  lead_q
);

    // R1: reset leaves every line high and no start.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cs_n == '1 && !start));

    // R2: outside a word the pins equal the idle-level register.
    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CSQ_IDLE) |-> (cs_n == idle_q));

    // R12: start never lasts two cycles.
    p_start_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R12: start only follows a cycle with a word offered.
    p_start_after_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(word_valid));

    // R6: with bypass set a word from idle starts at once.
    p_bypass_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CSQ_IDLE && word_valid && tmr_q) |=> start);

    // R4: a zero lead count starts at once.
    p_zero_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CSQ_IDLE && word_valid && lead_q == '0) |=> start);

    // R11: release is a single cycle followed by idle.
    p_release_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CSQ_RELEASE) |=> (st == CSQ_IDLE && !start));

    // R10: pins stay steady through a transfer unless the idle level is written.
    p_steady_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CSQ_XFER && $past(st) == CSQ_XFER && !$past(idle_wr))
            |-> $stable(cs_n));

endmodule

bind spi_csel_seq spi_csel_seq_chk #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .idle_wr(idle_wr),
    .start(start), .cs_n(cs_n), .st(st_q), .idle_q(idle_q),
    .tmr_q(tmr_q), .lead_q(lead_q)
);

// File: tb/spi_csel_seq_tb.sv
// Self-checking bench: a behavioural reference model compared every clock,
// plus directed measurements of waits, gaps and held selects.
module spi_csel_seq_tb;

    localparam int N  = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_wr = 1'b0, sel_hold = 1'b0;
    logic [N-1:0]  sel_n = '1;
    logic          dly_wr = 1'b0;
    logic [DW-1:0] dly_lead = '0, dly_trail = '0;
    logic          tmr_wr = 1'b0, tmr_off = 1'b0;
    logic          idle_wr = 1'b0;
    logic [N-1:0]  idle_lvl = '1;
    logic          word_valid = 1'b0, word_done = 1'b0;
    logic          start;
    logic [N-1:0]  cs_n;

    spi_csel_seq #(.NUM_CS(N), .DLY_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_n(sel_n), .sel_hold(sel_hold),
        .dly_wr(dly_wr), .dly_lead(dly_lead), .dly_trail(dly_trail),
        .tmr_wr(tmr_wr), .tmr_off(tmr_off),
        .idle_wr(idle_wr), .idle_lvl(idle_lvl),
        .word_valid(word_valid), .word_done(word_done),
        .start(start), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    int    checks = 0, errs = 0;
    string cur_req = "R1";
    bit    model_on = 1'b0;
    int    start_seen = 0;

    // ---------------- reference model ----------------
    int           m_ph, m_left, m_tr;
    logic [N-1:0] m_sel, m_def, w_sel;
    bit           m_hold, m_off, w_hold, w_off, m_start, n_start;
    int           m_lead, m_trail, w_trail;
    logic [N-1:0] exp_cs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_sel = '1; m_def = '1; m_hold = 0;
            m_off = 0; m_lead = 0; m_trail = 0; w_sel = '1; w_hold = 0;
            w_off = 0; w_trail = 0; m_start = 0;
        end else begin
            n_start = 0;
            case (m_ph)
                0: if (word_valid) begin
                       w_sel = m_sel; w_hold = m_hold; w_off = m_off; w_trail = m_trail;
                       if (m_off || m_lead == 0) begin m_ph = 2; n_start = 1; end
                       else begin m_ph = 1; m_left = m_lead; end
                   end
                1: if (m_left == 1) begin m_ph = 2; n_start = 1; end
                   else m_left = m_left - 1;
                2: if (word_done) begin
                       m_tr = w_off ? 0 : w_trail;
                       if (m_tr == 0) begin m_left = 0; m_ph = w_hold ? 3 : 4; end
                       else begin m_ph = 3; m_left = m_tr; end
                   end
                3: if (w_hold && word_valid) begin
                       w_sel = m_sel; w_hold = m_hold; w_off = m_off; w_trail = m_trail;
                       m_ph = 2; n_start = 1;
                   end else if (m_left > 1) m_left = m_left - 1;
                   else if (!w_hold) m_ph = 4;
                   else begin m_left = 0; if (!m_hold) m_ph = 4; end
                default: m_ph = 0;
            endcase
            if (sel_wr)  begin m_sel = sel_n; m_hold = sel_hold; end
            if (dly_wr)  begin m_lead = dly_lead; m_trail = dly_trail; end
            if (tmr_wr)  m_off = tmr_off;
            if (idle_wr) m_def = idle_lvl;
            m_start = n_start;
        end
        exp_cs = (m_ph == 0 || m_ph == 4) ? m_def : (m_def & w_sel);
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            checks++;
            if (cs_n !== exp_cs || start !== m_start) begin
                errs++;
                $display("FAIL %s model: cs_n=%b start=%b expected cs_n=%b start=%b",
                         cur_req, cs_n, start, exp_cs, m_start);
            end
            if (start) start_seen++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_sel(input logic [N-1:0] v, input logic h);
        sel_n = v; sel_hold = h; sel_wr = 1'b1;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic wr_dly(input int ld, input int tr);
        dly_lead = DW'(ld); dly_trail = DW'(tr); dly_wr = 1'b1;
        @(negedge clk); dly_wr = 1'b0;
    endtask

    task automatic wr_tmr(input logic v);
        tmr_off = v; tmr_wr = 1'b1;
        @(negedge clk); tmr_wr = 1'b0;
    endtask

    task automatic wr_idle(input logic [N-1:0] v);
        idle_lvl = v; idle_wr = 1'b1;
        @(negedge clk); idle_wr = 1'b0;
    endtask

    logic [N-1:0] cs_at_start;
    int lead_cnt, wait_cnt, trail_cnt;

    // Offer a word, wait for start, emulate the shift engine, optionally
    // measure the trail. Called and returns at a negedge.
    task automatic run_word(input int busy, input bit do_trail);
        lead_cnt = 0; wait_cnt = 0; trail_cnt = 0;
        word_valid = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (start) break;
            wait_cnt++;
            if (cs_n != m_def) lead_cnt++;
        end
        cs_at_start = cs_n;
        word_valid = 1'b0;
        repeat (busy) @(negedge clk);
        word_done = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        if (do_trail)
            while (cs_n != m_def && trail_cnt < 600) begin
                trail_cnt++;
                @(negedge clk);
            end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        int s0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;

        // R1: reset state
        cur_req = "R1";
        chk(cs_n == 2'b11, "R1 cs_n after reset", cs_n, 3);
        chk(start == 1'b0, "R1 start after reset", start, 0);

        // R2: idle level follows the idle register
        cur_req = "R2";
        wr_idle(2'b01);
        chk(cs_n == 2'b01, "R2 idle level", cs_n, 1);
        wr_idle(2'b11);
        chk(cs_n == 2'b11, "R2 idle level restored", cs_n, 3);

        // R3: selected line low, zero lead
        cur_req = "R3";
        wr_sel(2'b10, 1'b0);
        run_word(2, 1);
        chk(cs_at_start == 2'b10, "R3 line0 selected", cs_at_start, 2);
        chk(lead_cnt == 0, "R4 zero lead", lead_cnt, 0);
        chk(trail_cnt == 0, "R5 zero trail", trail_cnt, 0);
        wr_idle(2'b01);
        run_word(1, 1);
        chk(cs_at_start == 2'b00, "R3 unselected at idle level", cs_at_start, 0);
        wr_idle(2'b11);

        // R4 / R12: lead delay and single start
        cur_req = "R4";
        wr_dly(3, 0);
        s0 = start_seen;
        run_word(2, 1);
        chk(lead_cnt == 3, "R4 lead cycles", lead_cnt, 3);
        chk(start_seen - s0 == 1, "R12 one start per word", start_seen - s0, 1);

        // R5: trail delay
        cur_req = "R5";
        wr_dly(0, 4);
        run_word(1, 1);
        chk(trail_cnt == 4, "R5 trail cycles", trail_cnt, 4);

        // R6: bypass
        cur_req = "R6";
        wr_dly(5, 6);
        wr_tmr(1'b1);
        run_word(1, 1);
        chk(lead_cnt == 0, "R6 bypass lead", lead_cnt, 0);
        chk(trail_cnt == 0, "R6 bypass trail", trail_cnt, 0);
        wr_tmr(1'b0);

        // R7: hold across words
        cur_req = "R7";
        wr_dly(2, 3);
        wr_sel(2'b10, 1'b1);
        run_word(1, 0);
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (cs_n != 2'b10) n++;
        end
        chk(n == 0, "R7 select held while parked", n, 0);
        run_word(1, 0);
        chk(lead_cnt == 0 && wait_cnt == 0, "R7 held word starts next cycle", wait_cnt, 0);
        run_word(0, 0);
        chk(wait_cnt == 0 && cs_at_start == 2'b10, "R7 word inside trail wait", wait_cnt, 0);
        repeat (5) @(negedge clk);

        // R8: clearing the hold flag releases
        cur_req = "R8";
        wr_sel(2'b10, 1'b0);
        n = 0;
        while (cs_n != m_def && n < 50) begin n++; @(negedge clk); end
        chk(n == 1, "R8 release after hold cleared", n, 1);

        // R9: a field write alone starts nothing
        cur_req = "R9";
        wr_sel(2'b01, 1'b0);
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (start || cs_n != 2'b11) n++;
        end
        chk(n == 0, "R9 no start from field write", n, 0);

        // R10: mid-word writes apply to the next word only
        cur_req = "R10";
        wr_dly(0, 0);
        wr_sel(2'b10, 1'b0);
        word_valid = 1'b1;
        do @(negedge clk); while (!start);
        word_valid = 1'b0;
        wr_sel(2'b01, 1'b0);
        @(negedge clk);
        chk(cs_n == 2'b10, "R10 select unchanged mid-word", cs_n, 2);
        word_done = 1'b1; @(negedge clk); word_done = 1'b0;
        run_word(1, 1);
        chk(cs_at_start == 2'b01, "R10 new field on next word", cs_at_start, 1);

        // R11: back-to-back non-hold words
        cur_req = "R11";
        run_word(1, 0);
        run_word(1, 1);
        chk(wait_cnt == 1, "R11 release plus idle gap", wait_cnt, 1);

        // R13: word offered during a non-hold trail waits
        cur_req = "R13";
        wr_dly(0, 3);
        run_word(1, 0);
        run_word(1, 1);
        chk(wait_cnt == 4, "R13 deferred acceptance", wait_cnt, 4);
        chk(lead_cnt == 2, "R13 trail finished before accept", lead_cnt, 2);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule